// File: doc/BRIEF.md
# SAT Score and Learning-Probability Processor

This block scores each search iteration of a stochastic satisfiability solver and keeps the learning probabilities that steer the weight updates. For each iteration the clause evaluator presents one satisfied flag per clause. The block counts the set flags to form the score. It compares that score with the score of the previous accepted iteration to move a global probability up or down. It also records which clauses were left unsatisfied.

After each iteration the block runs a local pass over the active variables, lowest index first. For each variable it requests a flip of that one variable and waits for the evaluator to return the clause flags of the flipped assignment. It compares those flags with the stored unsatisfied set. If the net number of unsatisfied clauses falls, the variable's local probability rises. If the number grows, the probability falls. A one-cycle done pulse closes the pass. All probabilities are 8-bit values that move by a programmable step and saturate at 0 and 255.

Top module: `sat_lp_proc`

## Requirements
- R1: `score` equals the number of set bits in `iter_flags`. It is visible in the cycle after an iteration is accepted. An iteration is accepted when `iter_valid` is high while `flip_req` is low.
- R2: When the new score is greater than the score of the previous accepted iteration, `g_prob` rises by `step_g`, capped at 255.
- R3: When the new score is less than the previous score, `g_prob` falls by `step_g`, floored at 0.
- R4: `g_prob` does not change when the score is equal to the previous score, on the first iteration after reset, or at any time other than an iteration acceptance.
- R5: After an acceptance, `flip_req` rises in the next cycle with `flip_idx` set to the lowest active variable. Both hold steady until `flags_valid` is seen. The following cycle requests the next higher active variable.
- R6: For variable k, the change in unsatisfied count is (clauses unsatisfied in `flip_flags`) minus (clauses unsatisfied in the accepted `iter_flags`). If the change is negative, entry k of `l_prob` (bits k*8+7..k*8) rises by `step_l`, capped at 255.
- R7: If the change is positive, entry k falls by `step_l`, floored at 0. If the change is zero, entry k is unchanged.
- R8: A variable whose `var_active` bit is 0 is never requested, and its `l_prob` entry stays at its reset value.
- R9: `done` is a one-cycle pulse. It comes in the cycle after the last active variable's flags are accepted, or in the cycle after an acceptance when no variable is active.
- R10: `iter_valid` is ignored while `flip_req` is high. `flags_valid` is ignored while `flip_req` is low.
- R11: After reset, `score` is 0, `g_prob` and every `l_prob` entry are 128, and `flip_req` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iter_valid | input | 1 | New iteration's clause flags are present |
| iter_flags | input | 256 | Per-clause satisfied flags of the iteration |
| step_g | input | 8 | Step size for the global probability |
| step_l | input | 8 | Step size for the local probabilities |
| var_active | input | 64 | Variables used by the loaded problem |
| flip_req | output | 1 | Request for a single-variable flip evaluation |
| flip_idx | output | 6 | Variable to flip |
| flags_valid | input | 1 | `flip_flags` answers the current request |
| flip_flags | input | 256 | Clause flags with variable `flip_idx` flipped |
| score | output | 9 | Satisfied-clause count of the last accepted iteration |
| g_prob | output | 8 | Global learning probability |
| l_prob | output | 512 | Local probabilities, entry k at bits k*8+7..k*8 |
| done | output | 1 | Pulse at the end of a local pass |

## Verification
The assertions check the handshake and the timing on every cycle. They confirm that a requested index is active and that a pending request holds its index. They also confirm that `g_prob` moves only right after an acceptance, that `l_prob` moves only right after an answered flip, and that `done` has a legal cause and never coincides with a request. The arithmetic can only be shown by the bench scenarios: the score value, the direction and saturation of each probability step, and the net-count comparison in which a flip both satisfies and breaks a clause. The bench scenarios also cover an ignored intruding iteration, a stray answer while idle, and an empty active mask.

// File: rtl/sat_lp_pkg.sv
package sat_lp_pkg;

  // Control state of the local pass sequencer
  typedef enum logic {
    LP_IDLE = 1'b0,
    LP_FLIP = 1'b1
  } lp_state_e;

endpackage

// File: rtl/sat_lp_popcnt.sv
// Counts set bits of a flag vector.
module sat_lp_popcnt #(
  parameter int W  = 256,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);

  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      cnt = cnt + CW'(vec[i]);
    end
  end

endmodule

// File: rtl/sat_lp_prob_upd.sv
// Saturating up/down step of an unsigned probability.
module sat_lp_prob_upd #(
  parameter int PW = 8
) (
  input  logic [PW-1:0] cur,
  input  logic [PW-1:0] step,
  input  logic          up,
  input  logic          dn,
  output logic [PW-1:0] nxt
);

  logic [PW:0] sum;

  always_comb begin
    sum = {1'b0, cur} + {1'b0, step};
    nxt = cur;
    if (up) begin
      nxt = sum[PW] ? '1 : sum[PW-1:0];
    end else if (dn) begin
      nxt = (cur < step) ? '0 : (cur - step);
    end
  end

endmodule

// File: rtl/sat_lp_findnext.sv
// Lowest set bit of mask at or above start.
module sat_lp_findnext #(
  parameter int NV = 64,
  localparam int IW = $clog2(NV)
) (
  input  logic [NV-1:0] mask,
  input  logic [IW:0]   start,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NV - 1; i >= 0; i--) begin
      if (mask[i] && ((IW + 1)'(i) >= start)) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/sat_lp_proc.sv
module sat_lp_proc
  import sat_lp_pkg::*;
#(
  parameter int NC     = 256,
  parameter int NV     = 64,
  parameter int PW     = 8,
  parameter int G_INIT = 128,
  parameter int L_INIT = 128,
  localparam int CW = $clog2(NC + 1),
  localparam int IW = $clog2(NV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iter_valid,
  input  logic [NC-1:0]    iter_flags,
  input  logic [PW-1:0]    step_g,
  input  logic [PW-1:0]    step_l,
  input  logic [NV-1:0]    var_active,
  output logic             flip_req,
  output logic [IW-1:0]    flip_idx,
  input  logic             flags_valid,
  input  logic [NC-1:0]    flip_flags,
  output logic [CW-1:0]    score,
  output logic [PW-1:0]    g_prob,
  output logic [NV*PW-1:0] l_prob,
  output logic             done
);

  // Reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_s2_q, rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  assign rst_int_n = rst_s2_q;

  // State
  lp_state_e     state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          done_q, done_d;
  logic [CW-1:0] score_q;
  logic          have_prev_q;
  logic [PW-1:0] g_q, g_d;
  logic [NC-1:0] unsat_q;
  logic [PW-1:0] l_q [NV];

  logic accept_iter, accept_flip;
  assign accept_iter = (state_q == LP_IDLE) && iter_valid;
  assign accept_flip = (state_q == LP_FLIP) && flags_valid;

  // Iteration score and global step
  logic [CW-1:0] iter_cnt;
  logic          g_up, g_dn;

  sat_lp_popcnt #(.W(NC)) u_cnt_iter (
    .vec (iter_flags),
    .cnt (iter_cnt)
  );

  assign g_up = have_prev_q && (iter_cnt > score_q);
  assign g_dn = have_prev_q && (iter_cnt < score_q);

  sat_lp_prob_upd #(.PW(PW)) u_upd_g (
    .cur  (g_q),
    .step (step_g),
    .up   (g_up),
    .dn   (g_dn),
    .nxt  (g_d)
  );

  // Flip evaluation against the stored unsatisfied set
  logic [NC-1:0] gain_vec, lose_vec;
  logic [CW-1:0] gain_cnt, lose_cnt;
  logic          l_up, l_dn;
  logic [PW-1:0] l_cur, l_nxt;

  assign gain_vec = unsat_q & flip_flags;
  assign lose_vec = ~unsat_q & ~flip_flags;

  sat_lp_popcnt #(.W(NC)) u_cnt_gain (
    .vec (gain_vec),
    .cnt (gain_cnt)
  );

  sat_lp_popcnt #(.W(NC)) u_cnt_lose (
    .vec (lose_vec),
    .cnt (lose_cnt)
  );

  assign l_up  = gain_cnt > lose_cnt;
  assign l_dn  = lose_cnt > gain_cnt;
  assign l_cur = l_q[idx_q];

  sat_lp_prob_upd #(.PW(PW)) u_upd_l (
    .cur  (l_cur),
    .step (step_l),
    .up   (l_up),
    .dn   (l_dn),
    .nxt  (l_nxt)
  );

  // Next active variable search
  logic [IW:0]   scan_start;
  logic          scan_found;
  logic [IW-1:0] scan_idx;

  assign scan_start = accept_iter ? '0 : ({1'b0, idx_q} + {{IW{1'b0}}, 1'b1});

  sat_lp_findnext #(.NV(NV)) u_find (
    .mask  (var_active),
    .start (scan_start),
    .found (scan_found),
    .idx   (scan_idx)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    if (accept_iter) begin
      if (scan_found) begin
        state_d = LP_FLIP;
        idx_d   = scan_idx;
      end else begin
        done_d  = 1'b1;
      end
    end else if (accept_flip) begin
      if (scan_found) begin
        idx_d   = scan_idx;
      end else begin
        state_d = LP_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= LP_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (accept_iter || accept_flip) begin
        idx_q <= idx_d;
      end
    end
  end

  // Iteration registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      score_q     <= '0;
      have_prev_q <= 1'b0;
      g_q         <= PW'(G_INIT);
      unsat_q     <= '0;
    end else if (accept_iter) begin
      score_q     <= iter_cnt;
      have_prev_q <= 1'b1;
      g_q         <= g_d;
      unsat_q     <= ~iter_flags;
    end
  end

  // Local probability table
  for (genvar k = 0; k < NV; k++) begin : g_ltab
    logic we;
    assign we = accept_flip && (idx_q == IW'(k));

    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) begin
        l_q[k] <= PW'(L_INIT);
      end else if (we) begin
        l_q[k] <= l_nxt;
      end
    end

    assign l_prob[k*PW +: PW] = l_q[k];
  end

  assign flip_req = (state_q == LP_FLIP);
  assign flip_idx = idx_q;
  assign score    = score_q;
  assign g_prob   = g_q;
  assign done     = done_q;

endmodule

// File: rtl/sat_lp_proc_chk.sv
module sat_lp_proc_chk #(
  parameter int NC = 256,
  parameter int NV = 64,
  parameter int PW = 8,
  localparam int CW = $clog2(NC + 1),
  localparam int IW = $clog2(NV)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iter_valid,
  input logic             flags_valid,
  input logic [NV-1:0]    var_active,
  input logic             flip_req,
  input logic [IW-1:0]    flip_idx,
  input logic [CW-1:0]    score,
  input logic [PW-1:0]    g_prob,
  input logic [NV*PW-1:0] l_prob,
  input logic             done
);

  assert_score_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    score <= CW'(NC));

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flip_req && !flags_valid) |=> (flip_req && $stable(flip_idx)));

  assert_idx_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flip_req |-> var_active[flip_idx]);

  assert_g_only_on_iter_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(g_prob) |-> $past(iter_valid && !flip_req));

  assert_l_only_on_flip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(l_prob) |-> $past(flip_req && flags_valid));

  assert_done_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past((iter_valid && !flip_req) || (flip_req && flags_valid)));

  assert_done_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !flip_req);

endmodule

bind sat_lp_proc sat_lp_proc_chk #(.NC(NC), .NV(NV), .PW(PW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .iter_valid  (iter_valid),
  .flags_valid (flags_valid),
  .var_active  (var_active),
  .flip_req    (flip_req),
  .flip_idx    (flip_idx),
  .score       (score),
  .g_prob      (g_prob),
  .l_prob      (l_prob),
  .done        (done)
);

// File: tb/sat_lp_proc_tb.sv
module sat_lp_proc_tb;

  localparam int NC = 256;
  localparam int NV = 64;
  localparam int PW = 8;

  logic             clk;
  logic             rst_n;
  logic             iter_valid;
  logic [NC-1:0]    iter_flags;
  logic [PW-1:0]    step_g, step_l;
  logic [NV-1:0]    var_active;
  logic             flip_req;
  logic [5:0]       flip_idx;
  logic             flags_valid;
  logic [NC-1:0]    flip_flags;
  logic [8:0]       score;
  logic [PW-1:0]    g_prob;
  logic [NV*PW-1:0] l_prob;
  logic             done;

  sat_lp_proc u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .iter_valid  (iter_valid),
    .iter_flags  (iter_flags),
    .step_g      (step_g),
    .step_l      (step_l),
    .var_active  (var_active),
    .flip_req    (flip_req),
    .flip_idx    (flip_idx),
    .flags_valid (flags_valid),
    .flip_flags  (flip_flags),
    .score       (score),
    .g_prob      (g_prob),
    .l_prob      (l_prob),
    .done        (done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  // Reference model state
  int g_m;
  int l_m [NV];
  int prev_m;
  bit have_m;

  // Scoreboard of expected flip indices
  int exp_idx_q [$];

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] mk_base(input int n);
    logic [NC-1:0] b;
    for (int i = 0; i < NC / 4; i++) b[i*4 +: 4] = 4'b0101;
    for (int i = 0; i < n; i++) b[i*4 + 3] = 1'b1;
    return b;
  endfunction

  function automatic logic [NC-1:0] flip_of(input logic [NC-1:0] base, input int k);
    logic [NC-1:0] f;
    f = base;
    case (k % 3)
      0: f[k*4 + 1] = 1'b1;
      1: f[k*4] = 1'b0;
      default: begin
        f[k*4 + 1] = 1'b1;
        f[k*4]     = 1'b0;
      end
    endcase
    return f;
  endfunction

  // Monitor: compares each answered request against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && flip_req && flags_valid) begin
        if (exp_idx_q.size() == 0) begin
          check("R8 unexpected request", int'(flip_idx), -1);
        end else begin
          check("R5 request order", int'(flip_idx), exp_idx_q.pop_front());
        end
      end
    end
  end

  task automatic run_iter(input logic [NC-1:0] base, input int stall, input bit intrude);
    int cnt;
    int list [$];
    string tag;
    cnt = $countones(base);
    @(negedge clk);
    iter_valid = 1'b1;
    iter_flags = base;
    @(negedge clk);
    iter_valid = 1'b0;
    tag = "R4 first/equal";
    if (have_m && cnt > prev_m) begin
      g_m = (g_m + int'(step_g) > 255) ? 255 : g_m + int'(step_g);
      tag = "R2 rise";
    end else if (have_m && cnt < prev_m) begin
      g_m = (g_m < int'(step_g)) ? 0 : g_m - int'(step_g);
      tag = "R3 fall";
    end
    prev_m = cnt;
    have_m = 1'b1;
    check("R1 score", int'(score), cnt);
    check(tag, int'(g_prob), g_m);
    for (int k = 0; k < NV; k++) if (var_active[k]) list.push_back(k);
    foreach (list[i]) exp_idx_q.push_back(list[i]);
    if (list.size() == 0) begin
      check("R9 done empty", int'(done), 1);
      check("R8 no request", int'(flip_req), 0);
      @(negedge clk);
      check("R9 single pulse", int'(done), 0);
      return;
    end
    foreach (list[i]) begin
      int k;
      int d;
      k = list[i];
      check("R5 request up", int'(flip_req), 1);
      if (i == 0) begin
        for (int s = 0; s < stall; s++) begin
          iter_valid = intrude;
          iter_flags = mk_base(60);
          @(negedge clk);
          iter_valid = 1'b0;
          check("R5 hold req", int'(flip_req), 1);
          check("R5 hold idx", int'(flip_idx), k);
        end
      end
      flip_flags  = flip_of(base, k);
      flags_valid = 1'b1;
      @(negedge clk);
      flags_valid = 1'b0;
      d = (NC - $countones(flip_flags)) - (NC - cnt);
      if (d < 0) begin
        l_m[k] = (l_m[k] + int'(step_l) > 255) ? 255 : l_m[k] + int'(step_l);
        tag = "R6 local rise";
      end else if (d > 0) begin
        l_m[k] = (l_m[k] < int'(step_l)) ? 0 : l_m[k] - int'(step_l);
        tag = "R7 local fall";
      end else begin
        tag = "R7 local equal";
      end
      check(tag, int'(l_prob[k*PW +: PW]), l_m[k]);
      check("R9 done timing", int'(done), (i == list.size() - 1) ? 1 : 0);
    end
    check("R5 pass ended", int'(flip_req), 0);
    if (intrude) check("R10 intruding iteration", int'(score), cnt);
    @(negedge clk);
    check("R9 single pulse", int'(done), 0);
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    iter_valid  = 1'b0;
    iter_flags  = '0;
    flags_valid = 1'b0;
    flip_flags  = '0;
    step_g      = 8'd16;
    step_l      = 8'd40;
    var_active  = 64'h8000_0000_0000_0F25;
    g_m         = 128;
    prev_m      = 0;
    have_m      = 1'b0;
    for (int k = 0; k < NV; k++) l_m[k] = 128;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11 reset state
    check("R11 score", int'(score), 0);
    check("R11 g_prob", int'(g_prob), 128);
    check("R11 flip_req", int'(flip_req), 0);
    check("R11 done", int'(done), 0);
    for (int k = 0; k < NV; k++) check("R11 l_prob", int'(l_prob[k*PW +: PW]), 128);

    run_iter(mk_base(10), 3, 1'b1);
    run_iter(mk_base(20), 0, 1'b0);
    run_iter(mk_base(5),  2, 1'b0);
    run_iter(mk_base(5),  0, 1'b0);
    step_g = 8'd200;
    run_iter(mk_base(30), 0, 1'b0);
    run_iter(mk_base(10), 0, 1'b0);
    run_iter(mk_base(0),  0, 1'b0);

    // R10: stray answer while idle
    @(negedge clk);
    flip_flags  = '1;
    flags_valid = 1'b1;
    @(negedge clk);
    flags_valid = 1'b0;
    @(negedge clk);
    check("R10 idle flags no req", int'(flip_req), 0);
    check("R10 idle flags no done", int'(done), 0);
    for (int k = 0; k < NV; k++) check("R10 idle flags table", int'(l_prob[k*PW +: PW]), l_m[k]);

    // R9/R8: empty active mask
    var_active = '0;
    run_iter(mk_base(7), 0, 1'b0);

    // R8: inactive entries untouched
    for (int k = 0; k < NV; k++) begin
      if (!(64'h8000_0000_0000_0F25 >> k & 64'h1)) check("R8 inactive entry", int'(l_prob[k*PW +: PW]), 128);
    end
    check("R5 scoreboard drained", exp_idx_q.size(), 0);

    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule